// File: doc/BRIEF.md
# Serial Configuration Register Bank with Staged Updates

This block accepts configuration words over a three-wire serial link made of a serial clock, a data line and a load strobe. Bits enter a 32-bit shift register on each rising serial clock edge, most significant bit first. A rising edge on the load strobe commits the shifted word to one of six configuration registers. The three lowest bits of the word are the destination address. The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are detected in the system clock domain. The host must therefore hold every serial level for several system clock periods.

Some fields are double buffered. A write to their register records the new value in a staged copy, and the active copy keeps its old value until register 0 is written. The divider-select field of register 4 is staged only when the buffering-enable bit of register 2 is set. Every register-0 write, and the first cycle after reset, produces a one-cycle calibration-start pulse. The serial link is a plain control interface with no back-pressure. A word committed while a previous one is still in flight is never lost, because commits are spaced by the length of the serial transfer.

Top module: `serial_cfg_regfile`

## Requirements
- R1: Data is shifted in on the rising edge of the serial clock, most significant bit first. After 32 bits and a load strobe, the committed word equals the 32 bits in the order sent.
- R2: A commit with address bits [2:0] equal to 0 through 5 updates only the register with that index. All other active registers keep their values.
- R3: A commit with address 6 or 7 changes no register and produces no calibration pulse.
- R4: In registers 1 to 5, every bit outside the staged fields takes the written value in the commit cycle of its own write.
- R5: The staged fields keep their previous active value after a write to their register, until register 0 is written. These fields are register 1 bits [26:3] (phase [26:15], modulus [14:3]) and register 2 bits [25:14] and [12:9] (doubler 25, halver 24, reference count [23:14], pump current [12:9]).
- R6: A register-0 write makes its own full word active, and promotes all staged fields of registers 1, 2 and 4 to active, in the same clock cycle.
- R7: Register 4 bits [22:20] (divider select) are staged only if active register 2 bit 13 is 1 at the time of the write. Otherwise they take effect at once.
- R8: `cal_start` is high for exactly one cycle. It pulses in the first cycle after reset and in the cycle that the register-0 commit becomes visible.
- R9: Reset clears all active and staged registers and the shift register to zero.
- R10: `status_sel` equals active register 2 bits [28:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge commits the word |
| cfg_active | output | 192 | Active registers, register k at bits [32k+31:32k] |
| status_sel | output | 3 | Status multiplexer select from register 2 |
| cal_start | output | 1 | One-cycle calibration-start pulse |

## Verification
A wrong staged copy stays hidden until the next register-0 write. At that point it appears on the promoted fields of `cfg_active` in the commit cycle. The bench therefore follows every write with a full comparison of all six registers, and it sweeps writes to every address, including the two unused codes. A dropped or doubled serial bit shows as a shifted word, and a wrong address decode shows as a change in a register the write did not target. Both appear in the first comparison after that word's load strobe. The calibration pulse is counted continuously, so a missing or extra pulse is reported at the next check.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_REGS    = 6;
  localparam int ADDR_W      = 3;
  localparam int SYNC_STAGES = 2;

  localparam int DBUF_REG    = 2;
  localparam int DBUF_EN_BIT = 13;
  localparam int DIV_REG     = 4;
  localparam int DIV_LSB     = 20;
  localparam int DIV_W       = 3;
  localparam int MUX_LSB     = 26;
  localparam int MUX_W       = 3;

  function automatic logic [WORD_W-1:0] field_mask(int lsb, int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  // Fields that always wait for a register-0 write.
  function automatic logic [WORD_W-1:0] held_mask(int idx);
    case (idx)
      1:       return field_mask(3, 24);                       // phase + modulus
      2:       return field_mask(14, 12) | field_mask(9, 4);   // dbl, half, ref count, pump
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] div_mask();
    return field_mask(DIV_LSB, DIV_W);
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES*W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[(STAGES-1)*W-1:0], din};
  end

  assign dout = chain_q[STAGES*W-1 -: W];
endmodule

// File: rtl/scfg_edge.sv
module scfg_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         shift_en,
  input  logic         load_en,
  output logic         word_valid,
  output logic [W-1:0] word
);
  logic [W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      if (shift_en) shreg_q <= {shreg_q[W-2:0], bit_in};
      word_valid <= load_en;
      if (load_en) word <= shreg_q;
    end
  end
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
  import scfg_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int W    = WORD_W,
  parameter int AW   = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [W-1:0]    wr_word,
  output logic [NREG*W-1:0] active_flat,
  output logic            cal_start
);
  logic [AW-1:0]   addr;
  logic [NREG-1:0] hit;
  logic            div_buffered;
  logic            boot_q;

  assign addr         = wr_word[AW-1:0];
  assign div_buffered = active_flat[DBUF_REG*W + DBUF_EN_BIT];

  always_comb begin
    for (int k = 0; k < NREG; k++) hit[k] = wr_valid && (addr == AW'(k));
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [W-1:0] act_q;
    assign active_flat[k*W +: W] = act_q;

    if (k == 0) begin : g_primary
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     act_q <= '0;
        else if (hit[k]) act_q <= wr_word;
      end
    end else begin : g_buffered
      localparam logic [W-1:0] HELD  = held_mask(k);
      localparam logic [W-1:0] PROMO = HELD | ((k == DIV_REG) ? div_mask() : '0);
      logic [W-1:0] staged_q;
      logic [W-1:0] imm;

      always_comb begin
        imm = ~HELD;
        if (k == DIV_REG && div_buffered) imm = imm & ~div_mask();
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          staged_q <= '0;
          act_q    <= '0;
        end else if (hit[k]) begin
          staged_q <= wr_word;
          act_q    <= (act_q & ~imm) | (wr_word & imm);
        end else if (hit[0]) begin
          act_q    <= (act_q & ~PROMO) | (staged_q & PROMO);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      cal_start <= 1'b0;
    end else begin
      boot_q    <= 1'b0;
      cal_start <= boot_q | hit[0];
    end
  end
endmodule

// File: rtl/serial_cfg_regfile.sv
module serial_cfg_regfile
  import scfg_pkg::*;
#(
  parameter int NREG   = NUM_REGS,
  parameter int W      = WORD_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [NREG*W-1:0] cfg_active,
  output logic [MUX_W-1:0]  status_sel,
  output logic              cal_start
);
  logic [2:0]   pins_s;
  logic [1:0]   rise;
  logic         commit_valid;
  logic [W-1:0] commit_word;

  scfg_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_le, ser_clk, ser_data}),
    .dout(pins_s)
  );

  scfg_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .level(pins_s[2:1]),
    .rise(rise)
  );

  scfg_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_in(pins_s[0]),
    .shift_en(rise[0]),
    .load_en(rise[1]),
    .word_valid(commit_valid),
    .word(commit_word)
  );

  scfg_bank #(.NREG(NREG), .W(W), .AW(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(commit_valid),
    .wr_word(commit_word),
    .active_flat(cfg_active),
    .cal_start(cal_start)
  );

  assign status_sel = cfg_active[DBUF_REG*W + MUX_LSB +: MUX_W];
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
  import scfg_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic [WORD_W-1:0]          wr_word,
  input logic [NUM_REGS*WORD_W-1:0] active_flat,
  input logic                       cal_start
);
  logic [ADDR_W-1:0] addr;
  assign addr = wr_word[ADDR_W-1:0];

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  a_r6_cal_on_reg0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && addr == 0) |=> cal_start);

  a_r6_reg0_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && addr == 0) |=> active_flat[WORD_W-1:0] == $past(wr_word));

  a_r3_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && addr >= NUM_REGS) |=> ($stable(active_flat) && !cal_start));

  a_r5_held_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && addr == 1) |=>
      (((active_flat[WORD_W +: WORD_W] ^ $past(active_flat[WORD_W +: WORD_W]))
        & held_mask(1)) == '0));

  a_r2_other_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && addr == 3) |=>
      ($stable(active_flat[5*WORD_W +: WORD_W]) && $stable(active_flat[WORD_W-1:0])));
endmodule

bind serial_cfg_regfile scfg_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(commit_valid), .wr_word(commit_word),
  .active_flat(cfg_active), .cal_start(cal_start)
);

// File: tb/tb_serial_cfg_regfile.sv
`timescale 1ns/1ps
module tb_serial_cfg_regfile;
  logic clk = 0;
  logic rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_le = 0;
  logic [191:0] cfg_active;
  logic [2:0]   status_sel;
  logic         cal_start;

  int checks = 0, failures = 0, cal_seen = 0, cal_exp = 0;
  bit done = 0;
  logic [31:0] act [6];
  logic [31:0] stg [6];
  logic prev_cal = 0;

  localparam logic [31:0] HELD1 = 32'h07FF_FFF8;
  localparam logic [31:0] HELD2 = 32'h03FF_DE00;
  localparam logic [31:0] DIVM  = 32'h0070_0000;

  always #10 clk = ~clk;

  serial_cfg_regfile dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .cfg_active(cfg_active), .status_sel(status_sel),
    .cal_start(cal_start)
  );

  always @(posedge clk) begin
    if (rst_n && cal_start) cal_seen++;
    if (rst_n && cal_start && prev_cal) begin
      failures++;
      $display("FAIL R8 pulse wider than one cycle actual=2 expected=1");
    end
    prev_cal <= cal_start;
  end

  task automatic check(string tag, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  task automatic check_all(string tag, int a);
    @(negedge clk);
    for (int r = 0; r < 6; r++)
      check((r == a) ? "R2" : tag, cfg_active[r*32 +: 32], act[r]);
    check("R10", {29'd0, status_sel}, {29'd0, act[2][28:26]});
    check("R8", cal_seen, cal_exp);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      ser_data = w[i];
      hold(4); ser_clk = 1; hold(4); ser_clk = 0;
    end
    hold(4); ser_le = 1; hold(4); ser_le = 0; hold(6);
  endtask

  // Expected behaviour from the requirements.
  task automatic model(logic [31:0] w);
    int a = int'(w[2:0]);
    logic [31:0] held;
    if (a > 5) return;
    stg[a] = w;
    if (a == 0) begin
      act[0] = w;
      act[1] = (act[1] & ~HELD1) | (stg[1] & HELD1);
      act[2] = (act[2] & ~HELD2) | (stg[2] & HELD2);
      act[4] = (act[4] & ~DIVM)  | (stg[4] & DIVM);
      cal_exp++;
    end else begin
      held = (a == 1) ? HELD1 : (a == 2) ? HELD2 : (a == 4 && act[2][13]) ? DIVM : 32'h0;
      act[a] = (act[a] & held) | (w & ~held);
    end
  endtask

  task automatic write(logic [31:0] w);
    int a = int'(w[2:0]);
    string tag;
    send_word(w);
    model(w);
    tag = (a == 0) ? "R6" : (a >= 6) ? "R3" : (a == 1 || a == 2) ? "R5" : (a == 4) ? "R7" : "R4";
    check_all(tag, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 6; r++) begin act[r] = 0; stg[r] = 0; end
    hold(3); rst_n = 1; cal_exp = 1;
    hold(3);
    // R9: everything cleared; R8: boot pulse
    check_all("R9", -1);

    // R1: exact word order through register 0
    write(32'hA5C3_1E78);
    check("R1", cfg_active[31:0], 32'hA5C3_1E78);

    // R7: divider select immediate while reg2 bit13 = 0
    write(32'h0000_0002);
    write(32'h0050_0004);
    check("R7", {29'd0, cfg_active[4*32+20 +: 3]}, 32'd5);
    // buffering enabled: held until register 0
    write(32'h0000_2002);
    write(32'h0030_0004);
    check("R7", {29'd0, cfg_active[4*32+20 +: 3]}, 32'd5);
    write(32'h0000_0000);
    check("R7", {29'd0, cfg_active[4*32+20 +: 3]}, 32'd3);

    // Sweep every address with arithmetic patterns
    for (int rep = 0; rep < 4; rep++) begin
      for (int a = 0; a < 8; a++) begin
        logic [31:0] w;
        case (rep)
          0: w = 32'hFFFF_FFF8;
          1: w = 32'h0;
          default: w = (32'h9E37_79B9 * (rep * 8 + a + 1)) ^ (32'h1 << (a * 4 + rep));
        endcase
        write({w[31:3], a[2:0]});
      end
    end
    // R5: staged fields now promoted by a final register-0 write
    write(32'h1234_5670);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule